// File: doc/BRIEF.md
# Programmable-Resolution Watchdog Timer

This block watches a host processor for signs of life. Software writes one 8-bit configuration byte that holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout is the multiplier times the chosen resolution. The time base is a clock-enable pulse that arrives at 16 Hz. A prescaler divides that pulse into resolution ticks, and a down counter counts those ticks.

The host keeps the timer alive by toggling a kick input. Writing the configuration byte also restarts the timer. If the count runs out, the steering bit decides the outcome. It either produces a fixed-length reset pulse, or it raises a sticky watchdog flag together with an interrupt line. The host clears the flag and the interrupt with a read strobe. In both cases the timer reloads itself and keeps running. A multiplier of zero switches the watchdog off.

Top module: `wdt_core`

## Requirements
- R1: The configuration byte is laid out as follows. Bit 7 is the steering bit (1 = reset, 0 = interrupt), bits 6:2 are the multiplier and bits 1:0 are the resolution code. `cfg_o` shows the byte written by `cfg_wr`/`cfg_wdata` from the cycle after the write. After reset it reads 0x00.
- R2: Resolution codes 0, 1, 2 and 3 divide `base_en` by 1, 4, 16 and 64. Expiry happens on the (multiplier × divider)-th `base_en` pulse sampled after the restart cycle.
- R3: With a multiplier of zero, no expiry ever occurs. `rst_o`, `irq_o` and `flag_o` stay low.
- R4: A level change on `kick`, in either direction, restarts the full timeout. A `base_en` pulse in the same cycle is ignored.
- R5: A configuration write restarts the full timeout, using the newly written fields.
- R6: In reset steering, `rst_o` rises two clock cycles after the expiring `base_en` pulse is sampled. It stays high for exactly RST_LEN cycles (8 by default). `flag_o` and `irq_o` are unaffected.
- R7: In interrupt steering, `flag_o` and `irq_o` rise two cycles after the expiring `base_en` pulse and stay high until cleared. `rst_o` stays low.
- R8: A `flag_rd` pulse clears `flag_o` and `irq_o` in the following cycle.
- R9: After an expiry the timer reloads by itself. The next expiry follows one further full timeout without any kick.
- R10: After reset, all outputs are low and the watchdog is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_en | input | 1 | 16 Hz time-base enable, one clock wide |
| kick | input | 1 | Keep-alive level; any change restarts the timer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| flag_rd | input | 1 | Flag read strobe; clears flag and interrupt |
| cfg_o | output | 8 | Current configuration byte |
| flag_o | output | 1 | Sticky watchdog flag |
| irq_o | output | 1 | Interrupt request |
| rst_o | output | 1 | Reset pulse output |

## Verification
Expiry outputs are due two cycles after the base enable that completes the count. The bench issues enables four cycles apart and looks at the outputs after every cycle. From this it checks both the number of enables before the event and that nothing appears one cycle early. Configuration readback and flag clearing are due one cycle after their strobe, and they are sampled at the next falling edge. The reset pulse width is counted cycle by cycle from the first high sample.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CFG_W  = 8;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int PRE_W  = 2 * ((1 << RES_W) - 1);

  typedef struct packed {
    logic              steer_rst;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  // last prescaler count for a resolution code: divider 4**code, minus one
  function automatic logic [PRE_W-1:0] pre_limit(input logic [RES_W-1:0] code);
    logic [PRE_W:0] div;
    div = (PRE_W+1)'(1) << (2 * code);
    return PRE_W'(div - 1'b1);
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic            kick,
  output wdt_cfg_t        cfg_q,
  output logic            restart,
  output logic [MULT_W-1:0] load_mult
);
  logic kick_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      kick_d <= 1'b0;
    end else begin
      kick_d <= kick;
      if (wr_en) cfg_q <= wdt_cfg_t'(wdata);
    end
  end

  wdt_cfg_t wr_view;
  assign wr_view   = wdt_cfg_t'(wdata);
  assign restart   = wr_en | (kick ^ kick_d);
  assign load_mult = wr_en ? wr_view.mult : cfg_q.mult;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             base_en,
  input  logic             restart,
  input  logic [RES_W-1:0] res,
  output logic             res_tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] lim;

  assign lim      = pre_limit(res);
  assign res_tick = base_en && !restart && (pre_cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt <= '0;
    end else if (base_en) begin
      pre_cnt <= (pre_cnt == lim) ? '0 : pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int MW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [MW-1:0] load_val,
  input  logic [MW-1:0] reload_val,
  input  logic          res_tick,
  output logic          expire_q
);
  logic [MW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (restart) begin
        cnt <= load_val;
      end else if (res_tick && (cnt != '0)) begin
        if (cnt == MW'(1)) begin
          cnt      <= reload_val;
          expire_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer #(
  parameter int RST_LEN = 8,
  localparam int RW = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic steer_rst,
  input  logic flag_clr,
  output logic rst_o,
  output logic flag_o,
  output logic irq_o
);
  logic [RW-1:0] rst_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_left <= '0;
      rst_o    <= 1'b0;
    end else if (expire && steer_rst) begin
      rst_left <= RW'(RST_LEN);
      rst_o    <= 1'b1;
    end else if (rst_left != '0) begin
      rst_left <= rst_left - 1'b1;
      rst_o    <= (rst_left != RW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (expire && !steer_rst) begin
      flag_o <= 1'b1;
      irq_o  <= 1'b1;
    end else if (flag_clr) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int RST_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_en,
  input  logic             kick,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             flag_rd,
  output logic [CFG_W-1:0] cfg_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             rst_o
);
  wdt_cfg_t          cfg_q;
  logic              restart;
  logic [MULT_W-1:0] load_mult;
  logic              res_tick;
  logic              expire;

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wdata(cfg_wdata), .kick(kick),
    .cfg_q(cfg_q), .restart(restart), .load_mult(load_mult)
  );

  wdt_prescaler u_pre (
    .clk(clk), .rst(rst), .base_en(base_en), .restart(restart),
    .res(cfg_q.res), .res_tick(res_tick)
  );

  wdt_counter #(.MW(MULT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .load_val(load_mult),
    .reload_val(cfg_q.mult), .res_tick(res_tick), .expire_q(expire)
  );

  wdt_steer #(.RST_LEN(RST_LEN)) u_steer (
    .clk(clk), .rst(rst), .expire(expire), .steer_rst(cfg_q.steer_rst),
    .flag_clr(flag_rd), .rst_o(rst_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_o,
  input logic       expire,
  input logic       flag_rd,
  input logic       flag_o,
  input logic       irq_o,
  input logic       rst_o
);
  // R3: zero multiplier held for two cycles gives no expiry
  a_r3_zero_mult_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg_o[6:2] == 5'd0 && $past(cfg_o[6:2]) == 5'd0) |-> !expire);

  // R6: a reset pulse only starts from an expiry in reset steering
  a_r6_rst_source: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_o) |-> $past(expire && cfg_o[7]));

  // R7: flag only rises from an expiry in interrupt steering
  a_r7_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(expire && !cfg_o[7]));

  // R7: flag is sticky without a read
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_rd) |=> flag_o);

  // R7: interrupt line tracks the flag
  a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o == flag_o);

  // R8: read without a competing expiry clears the flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !(expire && !cfg_o[7])) |=> (!flag_o && !irq_o));
endmodule

bind wdt_core wdt_core_chk u_chk (
  .clk(clk), .rst(rst), .cfg_o(cfg_o), .expire(expire), .flag_rd(flag_rd),
  .flag_o(flag_o), .irq_o(irq_o), .rst_o(rst_o)
);

// File: tb/wdt_core_bench.sv
`timescale 1ns/1ps
module wdt_core_bench;
  localparam int RST_LEN = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_en = 1'b0;
  logic       kick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       flag_rd = 1'b0;
  logic [7:0] cfg_o;
  logic       flag_o, irq_o, rst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_core #(.RST_LEN(RST_LEN)) u_wdt_core (
    .clk(clk), .rst(rst), .base_en(base_en), .kick(kick), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .flag_rd(flag_rd), .cfg_o(cfg_o), .flag_o(flag_o),
    .irq_o(irq_o), .rst_o(rst_o)
  );

  function automatic int exp_ticks(input logic [7:0] c);
    return int'(c[6:2]) * (1 << (2 * int'(c[1:0])));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic cyc(input logic t);
    base_en = t;
    @(negedge clk);
    base_en = 1'b0;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    check(cfg_o == v, "R1 readback", cfg_o, v);
  endtask

  task automatic clear_flag();
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  // issue enables four cycles apart; returns enable count at first output, -1 if none
  task automatic run_to_expiry(input int limit, output int seen, output bit early);
    int ticks = 0;
    seen = -1;
    early = 1'b0;
    for (int i = 0; i < limit; i++) begin
      cyc(1'b1);
      ticks++;
      if (rst_o || irq_o) early = 1'b1;
      cyc(1'b0);
      if (rst_o || irq_o) begin
        seen = ticks;
        break;
      end
      cyc(1'b0);
      cyc(1'b0);
    end
  endtask

  task automatic pulse_width(output int w);
    w = 1;
    for (int i = 0; i < 4 * RST_LEN; i++) begin
      cyc(1'b0);
      if (!rst_o) break;
      w++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int seen, w, tgt;
    bit early;
    logic [7:0] c;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(cfg_o == 8'h00, "R10 cfg after reset", cfg_o, 0);
    check(!rst_o && !irq_o && !flag_o, "R10 outputs low", {rst_o, irq_o, flag_o}, 0);

    // R10/R3: disabled after reset, enables do nothing
    run_to_expiry(40, seen, early);
    check(seen == -1, "R10 idle after reset", seen, -1);

    // R2/R6: reset steering, mult 3, res 1 -> 12 enables
    c = {1'b1, 5'd3, 2'd1};
    write_cfg(c);
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c) && !early, "R2 timeout length", seen, exp_ticks(c));
    check(rst_o && !flag_o && !irq_o, "R6 reset steering only", {rst_o, flag_o, irq_o}, 4);
    pulse_width(w);
    check(w == RST_LEN, "R6 pulse width", w, RST_LEN);

    // R9: reload, next expiry after another full timeout
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c) && !early, "R9 auto reload", seen, exp_ticks(c));
    pulse_width(w);

    // R4: kick restarts (both edges)
    c = {1'b1, 5'd2, 2'd1};
    write_cfg(c);
    for (int i = 0; i < 6; i++) begin cyc(1'b1); cyc(1'b0); end
    kick = ~kick;
    cyc(1'b1);
    check(!rst_o, "R4 no expiry before kick window", rst_o, 0);
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c), "R4 rising kick restart", seen, exp_ticks(c));
    pulse_width(w);
    for (int i = 0; i < 5; i++) begin cyc(1'b1); cyc(1'b0); end
    kick = ~kick;
    cyc(1'b0);
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c), "R4 falling kick restart", seen, exp_ticks(c));
    pulse_width(w);

    // R5: write restarts with new fields
    for (int i = 0; i < 5; i++) begin cyc(1'b1); cyc(1'b0); end
    c = {1'b1, 5'd5, 2'd0};
    write_cfg(c);
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c), "R5 write restart", seen, exp_ticks(c));
    pulse_width(w);

    // R7: interrupt steering, sticky flag, no reset pulse
    c = {1'b0, 5'd2, 2'd2};
    write_cfg(c);
    run_to_expiry(200, seen, early);
    check(seen == exp_ticks(c) && !early, "R7 irq timeout", seen, exp_ticks(c));
    check(flag_o && irq_o && !rst_o, "R7 flag and irq set", {flag_o, irq_o, rst_o}, 6);
    repeat (20) cyc(1'b0);
    check(flag_o && irq_o, "R7 flag sticky", {flag_o, irq_o}, 3);
    // R8: read clears in next cycle
    clear_flag();
    check(!flag_o && !irq_o, "R8 read clears", {flag_o, irq_o}, 0);

    // R3: zero multiplier disables
    write_cfg({1'b1, 5'd0, 2'd0});
    run_to_expiry(300, seen, early);
    check(seen == -1 && !flag_o, "R3 zero multiplier quiet", seen, -1);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      c = {1'($urandom % 2), 5'(1 + $urandom % 3), 2'($urandom % 4)};
      tgt = exp_ticks(c);
      write_cfg(c);
      run_to_expiry(tgt + 8, seen, early);
      check(seen == tgt && !early, "R2 random timeout", seen, tgt);
      if (c[7]) begin
        check(rst_o && !flag_o, "R6 random steering", {rst_o, flag_o}, 2);
        pulse_width(w);
        check(w == RST_LEN, "R6 random pulse width", w, RST_LEN);
      end else begin
        check(flag_o && !rst_o, "R7 random steering", {flag_o, rst_o}, 2);
        clear_flag();
        check(!flag_o, "R8 random clear", flag_o, 0);
      end
    end
    finish_run();
  end
endmodule